// File: doc/BRIEF.md
# Per-Key Attack/Release Envelope Bank with Pulse-Width LFO

This block holds one amplitude level for each of 37 keys. Each level follows a linear attack/release envelope. A slow control tick, nominally about 61 Hz in a 16 MHz system (16 MHz / 1024 / 256), starts each update. On a tick the block captures the key gate vector and the rate parameters. It then walks through the keys one per clock cycle. A key whose gate is held climbs by the attack step toward full scale. A key whose gate is released decays by the release step toward silence. Both ends saturate, so the levels never wrap.

The same tick advances an 8-bit LFO phase by the LFO rate. The sine sample for that phase comes from a lookup the surrounding logic provides: the block drives the phase on `lfo_addr` and reads the sample back on `lfo_sine` in the same cycle. When the key sweep finishes, the block publishes a new pulse-width word for the oscillator bank. That word is the mid value minus the sine sample scaled by the depth parameter. The oscillators use the levels as per-voice gains and the pulse-width word as their shared duty threshold.

Top module: `keyenv_bank`

## Requirements
- R1: After reset, every key level is 0, the pulse-width word is 32767 and the LFO phase (`lfo_addr`) is 0.
- R2: On an update, a key whose captured gate is 1 and whose level is below 255 has the attack step added to its level, and the result is limited to 255.
- R3: On an update, a key whose captured gate is 0 and whose level is above 0 has the release step subtracted from its level, and the result is limited to 0.
- R4: An overshoot past either end is clamped, never wrapped. For example, 240 plus an attack step of 30 gives 255, and 7 minus a release step of 200 gives 0. A step of 0 leaves the level unchanged.
- R5: Each accepted tick advances `lfo_addr` by `lfo_rate`, modulo 256. The new pulse-width word is (32767 − `lfo_sine` × depth) modulo 65536, where `lfo_sine` is the sample returned for the advanced phase.
- R6: The tick is sampled at a clock edge E0. Key k takes its new level at edge E0+1+k, in ascending key order. The pulse-width word changes only at edge E0+37 and holds its old value before that edge.
- R7: The gate vector, the attack, release and depth values are captured on the tick edge. Changing them while a sweep is in progress has no effect on that sweep.
- R8: A tick that arrives while a sweep is in progress is ignored. It neither advances the phase nor starts a second update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle control tick that starts an update |
| gate | input | 37 | Key gate vector, bit k for key k |
| attack_rate | input | 8 | Attack step per update |
| release_rate | input | 8 | Release step per update |
| lfo_rate | input | 8 | Phase increment per update |
| lfo_depth | input | 8 | Scale factor for the sine sample |
| lfo_sine | input | 8 | Sine sample for the phase on `lfo_addr` |
| lfo_addr | output | 8 | Current LFO phase, used as the sine lookup address |
| level_flat | output | 296 | Key levels; key k occupies bits [8k+7:8k] |
| pulse_width | output | 16 | Shared pulse-width word |

## Verification
The bench targets the saturation edges. Directed ramps run 240 up by 30 and 7 down by 200, and steps of 255 and 0 are applied. A design that kept only eight bits of the sum would wrap a loud key to near silence, or a quiet key to near full scale.

Timing is checked at the exact edges: key 0 against key 36 just after the first sweep cycle, and the pulse-width word one cycle before and at the sweep's end. A design that published the LFO result early, or swept in the wrong order, would fail these checks.

Gates and rates are flipped in mid-sweep, and a second tick is sent in mid-sweep. A design that did not capture its inputs on the tick, or that restarted the sweep, would produce levels or a phase that differ from a single update. Depth values up to 255 force the pulse-width subtraction to wrap below zero.

// File: rtl/keyenv_bank.sv
module keyenv_bank #(
  parameter int NKEYS  = 37,
  parameter int LVL_W  = 8,
  parameter int RATE_W = 8,
  parameter int PH_W   = 8,
  parameter int SINE_W = 8,
  parameter int PW_W   = 16,
  parameter int PW_MID = 32767
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   tick,
  input  logic [NKEYS-1:0]       gate,
  input  logic [RATE_W-1:0]      attack_rate,
  input  logic [RATE_W-1:0]      release_rate,
  input  logic [RATE_W-1:0]      lfo_rate,
  input  logic [RATE_W-1:0]      lfo_depth,
  input  logic [SINE_W-1:0]      lfo_sine,
  output logic [PH_W-1:0]        lfo_addr,
  output logic [NKEYS*LVL_W-1:0] level_flat,
  output logic [PW_W-1:0]        pulse_width
);

  localparam int IDX_W   = (NKEYS > 1) ? $clog2(NKEYS) : 1;
  localparam int ACC_W   = ((LVL_W > RATE_W) ? LVL_W : RATE_W) + 2;
  localparam int PROD_W  = SINE_W + RATE_W;
  localparam int LVL_MAX = (1 << LVL_W) - 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NKEYS - 1);

  logic [NKEYS-1:0][LVL_W-1:0] lvl;
  logic [NKEYS-1:0]            gate_q;
  logic [RATE_W-1:0]           atk_q, rel_q, dep_q;
  logic [PH_W-1:0]             phase;
  logic [PW_W-1:0]             pw_q;
  logic [IDX_W-1:0]            idx;
  logic                        busy;

  logic [LVL_W-1:0]        cur, nxt;
  logic                    cur_gate;
  logic signed [ACC_W-1:0] up_sum, dn_sum;
  logic [PROD_W-1:0]       prod;
  logic [PW_W-1:0]         pw_next;

  assign cur      = lvl[idx];
  assign cur_gate = gate_q[idx];
  assign up_sum   = $signed(ACC_W'(cur)) + $signed(ACC_W'(atk_q));
  assign dn_sum   = $signed(ACC_W'(cur)) - $signed(ACC_W'(rel_q));

  always_comb begin
    nxt = cur;
    if (cur_gate) begin
      if (cur != LVL_W'(LVL_MAX))
        nxt = (up_sum > $signed(ACC_W'(LVL_MAX))) ? LVL_W'(LVL_MAX) : up_sum[LVL_W-1:0];
    end else begin
      if (cur != '0)
        nxt = (dn_sum < 0) ? '0 : dn_sum[LVL_W-1:0];
    end
  end

  assign prod    = PROD_W'(lfo_sine) * PROD_W'(dep_q);
  assign pw_next = PW_W'(PW_MID) - PW_W'(prod);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl    <= '0;
      gate_q <= '0;
      atk_q  <= '0;
      rel_q  <= '0;
      dep_q  <= '0;
      phase  <= '0;
      pw_q   <= PW_W'(PW_MID);
      idx    <= '0;
      busy   <= 1'b0;
    end else if (!busy) begin
      if (tick) begin
        gate_q <= gate;
        atk_q  <= attack_rate;
        rel_q  <= release_rate;
        dep_q  <= lfo_depth;
        phase  <= phase + PH_W'(lfo_rate);
        idx    <= '0;
        busy   <= 1'b1;
      end
    end else begin
      lvl[idx] <= nxt;
      if (idx == LAST) begin
        busy <= 1'b0;
        pw_q <= pw_next;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign lfo_addr    = phase;
  assign level_flat  = lvl;
  assign pulse_width = pw_q;

  // R2
  attack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cur_gate |=> lvl[$past(idx)] >= $past(cur));

  // R3
  release_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cur_gate |=> lvl[$past(idx)] <= $past(cur));

  // R5
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && tick |=> lfo_addr == $past(lfo_addr) + $past(lfo_rate));

  // R6
  pw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && idx == LAST) |=> $stable(pulse_width));

  // R6
  sweep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && idx == LAST |=> !busy);

  // R8
  busy_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && tick |=> $stable(lfo_addr));

endmodule

// File: tb/keyenv_bank_bench.sv
module keyenv_bank_bench;
  localparam int N = 37;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [N-1:0] gate = '0;
  logic [7:0]   attack_rate = 8'd30, release_rate = 8'd3, lfo_rate = 8'd8, lfo_depth = 8'd120;
  logic [7:0]   lfo_sine;
  logic [7:0]   lfo_addr;
  logic [N*8-1:0] level_flat;
  logic [15:0]  pulse_width;

  int total = 0, bad = 0;
  int sine_tab [256];
  int m_lvl [N];
  int m_phase, m_pw;

  always #2 clk = ~clk;

  assign lfo_sine = 8'(sine_tab[lfo_addr]);

  keyenv_bank u_keyenv_bank (
    .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
    .attack_rate(attack_rate), .release_rate(release_rate),
    .lfo_rate(lfo_rate), .lfo_depth(lfo_depth), .lfo_sine(lfo_sine),
    .lfo_addr(lfo_addr), .level_flat(level_flat), .pulse_width(pulse_width)
  );

  function automatic int lvl_of(int k);
    return int'(level_flat[k*8 +: 8]);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_tick();
    m_phase = (m_phase + int'(lfo_rate)) & 255;
    for (int k = 0; k < N; k++) begin
      if (gate[k] && m_lvl[k] < 255) begin
        m_lvl[k] = m_lvl[k] + int'(attack_rate);
        if (m_lvl[k] > 255) m_lvl[k] = 255;
      end else if (!gate[k] && m_lvl[k] > 0) begin
        m_lvl[k] = m_lvl[k] - int'(release_rate);
        if (m_lvl[k] < 0) m_lvl[k] = 0;
      end
    end
    m_pw = (32767 - sine_tab[m_phase] * int'(lfo_depth)) & 16'hFFFF;
  endtask

  task automatic check_all(input string tag);
    int errs = 0;
    for (int k = 0; k < N; k++) begin
      if (lvl_of(k) != m_lvl[k]) begin
        errs++;
        chk(1'b0, $sformatf("%s key%0d", tag, k), lvl_of(k), m_lvl[k]);
      end
    end
    if (errs == 0) chk(1'b1, tag, 0, 0);
    chk(int'(pulse_width) == m_pw, {tag, " pw"}, int'(pulse_width), m_pw);
    chk(int'(lfo_addr) == m_phase, {tag, " phase"}, int'(lfo_addr), m_phase);
  endtask

  task automatic run_tick();
    @(negedge clk); tick = 1'b1;
    model_tick();
    @(negedge clk); tick = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    int old_pw;
    seed = int'($urandom(32'd4242));
    for (int i = 0; i < 256; i++)
      sine_tab[i] = int'(127.0 + 127.0 * $sin(6.283185307179586 * i / 256.0) + 0.5);
    for (int k = 0; k < N; k++) m_lvl[k] = 0;
    m_phase = 0; m_pw = 32767;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R2 R4: ramp with default rates, saturation from 240 by 30
    gate = '1;
    for (int t = 0; t < 10; t++) run_tick();
    check_all("R2 R4 attack ramp");
    chk(lvl_of(0) == 255, "R4 saturate at top", lvl_of(0), 255);

    // R3: release from 255 by 3
    gate = '0;
    for (int t = 0; t < 3; t++) run_tick();
    check_all("R3 release");

    // R4: zero steps leave levels alone
    attack_rate = 8'd0; release_rate = 8'd0; gate = {N/2{2'b01}};
    run_tick();
    check_all("R4 zero step");

    // R4: clamp at bottom, 7 - 200
    release_rate = 8'd248; gate = '0; run_tick();
    attack_rate = 8'd7; gate = '1; run_tick();
    release_rate = 8'd200; gate = '0; run_tick();
    check_all("R4 clamp at bottom");
    chk(lvl_of(5) == 0, "R4 7-200", lvl_of(5), 0);

    // R4: full step 255 in one tick
    attack_rate = 8'd255; gate = 37'h1; run_tick();
    check_all("R4 full step");

    // R5: deep modulation wraps pulse width
    lfo_depth = 8'd255; lfo_rate = 8'd64;
    for (int t = 0; t < 4; t++) run_tick();
    check_all("R5 pw wrap");

    // R6: exact edge timing
    gate = '1; attack_rate = 8'd10; lfo_rate = 8'd19; lfo_depth = 8'd90;
    release_rate = 8'd1;
    old_pw = m_pw;
    @(negedge clk); tick = 1'b1;
    model_tick();
    @(negedge clk); tick = 1'b0;
    @(negedge clk);
    chk(lvl_of(0) == m_lvl[0], "R6 key0 first", lvl_of(0), m_lvl[0]);
    chk(lvl_of(36) != m_lvl[36], "R6 key36 not yet", lvl_of(36), m_lvl[36]);
    repeat (35) @(negedge clk);
    chk(int'(pulse_width) == old_pw, "R6 pw held before end", int'(pulse_width), old_pw);
    @(negedge clk);
    chk(int'(pulse_width) == m_pw, "R6 pw at end", int'(pulse_width), m_pw);
    chk(lvl_of(36) == m_lvl[36], "R6 key36 last", lvl_of(36), m_lvl[36]);
    repeat (4) @(negedge clk);

    // R7 R8: change inputs and re-tick mid-sweep
    gate = 37'h0F0F0F0F0F; attack_rate = 8'd40; release_rate = 8'd25; lfo_depth = 8'd33;
    @(negedge clk); tick = 1'b1;
    model_tick();
    @(negedge clk); tick = 1'b0;
    gate = ~gate; attack_rate = 8'd200; release_rate = 8'd200; lfo_depth = 8'd250;
    repeat (5) @(negedge clk);
    tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    repeat (40) @(negedge clk);
    check_all("R7 R8 mid-sweep changes");

    // random traffic, R2 R3 R5
    for (int t = 0; t < 60; t++) begin
      gate = {5'($urandom), $urandom};
      attack_rate = 8'($urandom); release_rate = 8'($urandom);
      lfo_rate = 8'($urandom); lfo_depth = 8'($urandom);
      if (t % 7 == 0) attack_rate = 8'd255;
      if (t % 5 == 0) release_rate = 8'd255;
      run_tick();
      check_all("R2 R3 R5 random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule